// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

A purely combinational binary adder that forms every carry by lookahead instead of letting it ripple from bit to bit. The operand word is cut into equal slices. Inside each slice, every bit position derives a generate term (both operand bits set) and a propagate term (exactly one operand bit set). A flat sum-of-products network then produces all of the slice's internal carries at once. Each slice also condenses itself into a single group generate and group propagate pair.

A second lookahead network of the same kind takes the slice pairs and the external carry-in. It delivers the carry into every slice and the final carry-out, again without any chain. The top-level group generate and group propagate are brought out as ports, so one or more of these adders can sit beneath a further lookahead level to build a wider word.

With the default parameters the block is a 16-bit adder made from four 4-bit slices. One lookahead module is reused, unchanged, for both the slice level and the second level.

Top module: `hcla_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i` + `c_in`) modulo 2^WIDTH, for every operand pair and both carry-in values.
- R2: `c_out` equals bit WIDTH of the full sum `a_i` + `b_i` + `c_in`.
- R3: `grp_gen_o` is 1 exactly when `a_i` + `b_i` is at least 2^WIDTH, that is, when the word produces a carry whatever `c_in` is.
- R4: `grp_prop_o` is 1 exactly when `a_i` + `b_i` equals 2^WIDTH - 1, that is, when every bit position propagates.
- R5: With every bit propagating (`b_i` = ~`a_i`) and `c_in` = 1, `sum_o` is 0, `c_out` is 1, `grp_prop_o` is 1 and `grp_gen_o` is 0.
- R6: With both operands 0, `sum_o` equals `c_in` and `c_out`, `grp_gen_o` and `grp_prop_o` are all 0.
- R7: With both operands all ones, `sum_o` is all ones except bit 0, which equals `c_in`; `c_out` and `grp_gen_o` are 1 and `grp_prop_o` is 0.
- R8: `c_out` always equals `grp_gen_o` OR (`grp_prop_o` AND `c_in`), so the pair can stand in for the whole word at a further lookahead level.
- R9: A carry born in bit 0 crosses every slice boundary: `a_i` all ones, `b_i` = 1 and `c_in` = 0 give `sum_o` = 0 and `c_out` = 1. The same carry stopping at a single slice boundary gives a one in that slice's lowest bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH (16) | First operand |
| b_i | input | WIDTH (16) | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH (16) | Sum, modulo 2^WIDTH |
| c_out | output | 1 | Carry out of the top bit |
| grp_gen_o | output | 1 | Word-level group generate |
| grp_prop_o | output | 1 | Word-level group propagate |

## Verification
The bench builds two copies of the adder. The first uses the defaults: four 4-bit slices, 16 bits in all. It receives random operands and the forced patterns that the requirements name, such as full propagation, all zeros, all ones and carries stopping at each slice edge. The second uses three 2-bit slices, a 6-bit word, which brings every operand pair and carry-in within reach in 8192 cycles. That copy therefore checks the sum, carry-out and both group outputs exhaustively, including the odd slice count at the second level.

// File: rtl/hcla_pkg.sv
package hcla_pkg;

    // Default slicing of the operand word.
    localparam int DEF_SLICE_W    = 4;
    localparam int DEF_NUM_SLICES = 4;

    // Condensed carry behaviour of a run of bits.
    typedef struct packed {
        logic gen;
        logic prop;
    } grp_t;

endpackage

// File: rtl/hcla_lookahead.sv
// Flat lookahead carry network over N generate/propagate pairs.
// carry_o[0] is the incoming carry, carry_o[N] the carry leaving the run.
module hcla_lookahead #(
    parameter int N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    input  logic         c_in,
    output logic [N:0]   carry_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);

    // Each carry is an OR of product terms: a generate at position j
    // followed by propagates j+1..i, plus c_in through propagates 0..i.
    always_comb begin
        logic run_p;
        logic term;
        carry_o[0] = c_in;
        for (int i = 0; i < N; i++) begin
            term = 1'b0;
            for (int j = 0; j <= i; j++) begin
                run_p = gen_i[j];
                for (int k = j + 1; k <= i; k++) begin
                    run_p = run_p & prop_i[k];
                end
                term = term | run_p;
            end
            run_p = c_in;
            for (int k = 0; k <= i; k++) begin
                run_p = run_p & prop_i[k];
            end
            carry_o[i+1] = term | run_p;
        end
    end

    // Group generate: the same product terms for the top carry, without c_in.
    always_comb begin
        logic run_g;
        grp_gen_o = 1'b0;
        for (int j = 0; j < N; j++) begin
            run_g = gen_i[j];
            for (int k = j + 1; k < N; k++) begin
                run_g = run_g & prop_i[k];
            end
            grp_gen_o = grp_gen_o | run_g;
        end
    end

    assign grp_prop_o = &prop_i;

    // Checks on the relation between the flat carries and the group pair.
    always_comb begin
        if (grp_gen_o) begin
            a_r3_gen_forces_carry: assert (carry_o[N])
                else $error("R3: group generate set but no carry out");
        end
        a_r8_pair_predicts_carry: assert (carry_o[N] == (grp_gen_o | (grp_prop_o & c_in)))
            else $error("R8: carry out disagrees with group pair");
        if (grp_prop_o) begin
            a_r4_prop_passes_cin: assert (carry_o == {(N+1){c_in}})
                else $error("R4: full propagate but carries differ from c_in");
        end
    end

endmodule

// File: rtl/hcla_slice.sv
// One W-bit lookahead slice: bit-level generate/propagate, flat carries,
// sum bits and the exported group pair.
module hcla_slice #(
    parameter int W = 4
) (
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          c_in,
    output logic [W-1:0]  sum_o,
    output hcla_pkg::grp_t grp_o
);

    logic [W-1:0] bit_gen;
    logic [W-1:0] bit_prop;
    logic [W:0]   carry;
    logic         slice_gg;
    logic         slice_gp;

    assign bit_gen  = a_i & b_i;
    assign bit_prop = a_i ^ b_i;

    hcla_lookahead #(.N(W)) u_lcu (
        .gen_i     (bit_gen),
        .prop_i    (bit_prop),
        .c_in      (c_in),
        .carry_o   (carry),
        .grp_gen_o (slice_gg),
        .grp_prop_o(slice_gp)
    );

    // The carry leaving the slice (carry[W]) is not needed for any sum bit.
    assign sum_o      = bit_prop ^ carry[W-1:0];
    assign grp_o.gen  = slice_gg;
    assign grp_o.prop = slice_gp;

    always_comb begin
        a_r1_low_bit_sum: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ c_in))
            else $error("R1: slice bit 0 sum wrong");
    end

endmodule

// File: rtl/hcla_adder.sv
// Two-level carry lookahead adder: NUM_SLICES slices of SLICE_W bits, with a
// second lookahead network supplying the slice carries and the carry-out.
module hcla_adder #(
    parameter int SLICE_W    = hcla_pkg::DEF_SLICE_W,
    parameter int NUM_SLICES = hcla_pkg::DEF_NUM_SLICES,
    localparam int WIDTH     = SLICE_W * NUM_SLICES
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_out,
    output logic             grp_gen_o,
    output logic             grp_prop_o
);

    hcla_pkg::grp_t [NUM_SLICES-1:0] slice_grp;
    logic [NUM_SLICES-1:0]           slice_gg;
    logic [NUM_SLICES-1:0]           slice_gp;
    logic [NUM_SLICES:0]             slice_carry;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        hcla_slice #(.W(SLICE_W)) u_slice (
            .a_i  (a_i[s*SLICE_W +: SLICE_W]),
            .b_i  (b_i[s*SLICE_W +: SLICE_W]),
            .c_in (slice_carry[s]),
            .sum_o(sum_o[s*SLICE_W +: SLICE_W]),
            .grp_o(slice_grp[s])
        );
        assign slice_gg[s] = slice_grp[s].gen;
        assign slice_gp[s] = slice_grp[s].prop;
    end

    // Second level: the same lookahead network over the slice pairs.
    hcla_lookahead #(.N(NUM_SLICES)) u_lcu_l2 (
        .gen_i     (slice_gg),
        .prop_i    (slice_gp),
        .c_in      (c_in),
        .carry_o   (slice_carry),
        .grp_gen_o (grp_gen_o),
        .grp_prop_o(grp_prop_o)
    );

    assign c_out = slice_carry[NUM_SLICES];

    always_comb begin
        a_r2_cout_from_top_slice: assert (c_out ==
                (slice_gg[NUM_SLICES-1] | (slice_gp[NUM_SLICES-1] & slice_carry[NUM_SLICES-1])))
            else $error("R2: carry out disagrees with top slice");
        if (grp_prop_o) begin
            a_r5_full_prop_sum: assert (sum_o == {WIDTH{~c_in}})
                else $error("R5: full propagate sum wrong");
        end
    end

endmodule

// File: tb/tb_hcla_adder.sv
`timescale 1ns/1ps
module tb_hcla_adder;

    localparam int W_BIG   = 16;
    localparam int W_SMALL = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [W_BIG-1:0]   a, b, s;
    logic               ci, co, gg, gp;
    logic [W_SMALL-1:0] a_s, b_s, s_s;
    logic               ci_s, co_s, gg_s, gp_s;

    hcla_adder dut (
        .a_i(a), .b_i(b), .c_in(ci),
        .sum_o(s), .c_out(co), .grp_gen_o(gg), .grp_prop_o(gp)
    );

    hcla_adder #(.SLICE_W(2), .NUM_SLICES(3)) dut_small (
        .a_i(a_s), .b_i(b_s), .c_in(ci_s),
        .sum_o(s_s), .c_out(co_s), .grp_gen_o(gg_s), .grp_prop_o(gp_s)
    );

    // Expected tuple packed as {gen, prop, cout, sum[15:0]}.
    typedef struct {
        logic [18:0] exp_big;
        logic [18:0] exp_small;
        string       tag;
    } item_t;

    item_t queue_q[$];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    function automatic logic [18:0] model(int w, logic [15:0] x, logic [15:0] y, logic c);
        longint full, pair, lim;
        logic [15:0] sm;
        lim  = longint'(1) << w;
        pair = longint'(x) + longint'(y);
        full = pair + longint'(c);
        sm   = 16'(full % lim);
        return {(pair >= lim), (pair == lim - 1), (full >= lim), sm};
    endfunction

    task automatic drive(logic [15:0] x, logic [15:0] y, logic c,
                         logic [5:0] xs, logic [5:0] ys, logic cs, string tag);
        item_t it;
        @(posedge clk);
        a = x; b = y; ci = c;
        a_s = xs; b_s = ys; ci_s = cs;
        it.exp_big   = model(W_BIG, x, y, c);
        it.exp_small = model(W_SMALL, {10'd0, xs}, {10'd0, ys}, cs);
        it.tag = tag;
        queue_q.push_back(it);
    endtask

    // Monitor: compares one queued expectation per cycle, mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && queue_q.size() > 0) begin
                item_t it;
                logic [18:0] act_b, act_s;
                it = queue_q.pop_front();
                act_b = {gg, gp, co, s};
                act_s = {gg_s, gp_s, co_s, 10'd0, s_s};
                checks++;
                if (act_b !== it.exp_big) begin
                    errors++;
                    $display("FAIL %s (16-bit): got gg/gp/co/sum=%h expected %h",
                             it.tag, act_b, it.exp_big);
                end
                checks++;
                if (act_s !== it.exp_small) begin
                    errors++;
                    $display("FAIL %s (6-bit): got gg/gp/co/sum=%h expected %h",
                             it.tag, act_s, it.exp_small);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, got no completion expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] rx, ry;
        a = '0; b = '0; ci = 1'b0;
        a_s = '0; b_s = '0; ci_s = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset state, all zero inputs: R6
        @(negedge clk);
        checks++;
        if ({gg, gp, co, s} !== 19'd0) begin
            errors++;
            $display("FAIL R6 idle: got %h expected 0", {gg, gp, co, s});
        end

        // Corner patterns
        drive(16'h0000, 16'h0000, 1'b0, 6'h00, 6'h00, 1'b0, "R6 zeros cin0");
        drive(16'h0000, 16'h0000, 1'b1, 6'h00, 6'h00, 1'b1, "R6 zeros cin1");
        drive(16'hA5C3, 16'h5A3C, 1'b1, 6'h2B, 6'h14, 1'b1, "R5 full propagate cin1");
        drive(16'h1234, 16'hEDCB, 1'b0, 6'h15, 6'h2A, 1'b0, "R4 full propagate cin0");
        drive(16'hFFFF, 16'hFFFF, 1'b0, 6'h3F, 6'h3F, 1'b0, "R7 all ones cin0");
        drive(16'hFFFF, 16'hFFFF, 1'b1, 6'h3F, 6'h3F, 1'b1, "R7 all ones cin1");
        drive(16'hFFFF, 16'h0001, 1'b0, 6'h3F, 6'h01, 1'b0, "R9 carry through all slices");
        drive(16'h000F, 16'h0001, 1'b0, 6'h03, 6'h01, 1'b0, "R9 stop at slice 1");
        drive(16'h00FF, 16'h0001, 1'b0, 6'h0F, 6'h01, 1'b0, "R9 stop at slice 2");
        drive(16'h0FFF, 16'h0000, 1'b1, 6'h0F, 6'h00, 1'b1, "R9 stop at slice 3 via cin");
        drive(16'h8000, 16'h8000, 1'b0, 6'h20, 6'h20, 1'b0, "R3 generate top bit only");
        drive(16'h8000, 16'h8000, 1'b1, 6'h20, 6'h20, 1'b1, "R8 generate with cin");

        // Random 16-bit operands; small copy runs exhaustively alongside.
        for (int x = 0; x < 64; x++) begin
            for (int y = 0; y < 64; y++) begin
                for (int c = 0; c < 2; c++) begin
                    rx = 16'($urandom);
                    ry = 16'($urandom);
                    drive(rx, ry, 1'($urandom), 6'(x), 6'(y), 1'(c),
                          "R1 R2 R3 R4 R8 sweep");
                end
            end
        end

        while (queue_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule